// File: doc/BRIEF.md
# Latch-Paced Serial Byte Shifter

This block drains bytes from a scan-code queue and clocks each one, bit by bit, into an external serial-in parallel-out register that a host console port reads in parallel. Flow control comes from an external set/reset latch. The host sets the latch once it has taken the current byte. The shifter sends only while the latch output reads high. When a byte is complete, it pulses the latch reset to clear the latch output and so tell the host that fresh data is waiting.

The serial data pin is shared with the PS/2 keyboard data line. For that reason the block raises an output-enable only while it is shifting, and leaves the pin released at all other times. A hold output tells the PS/2 receiver to ignore line activity for the whole transfer. The shift clock half-period, the word width and the depth of the latch-input synchronizer are parameters.

Top module: `latch_paced_shifter`

## Requirements
- R1: After reset `sclk` is 1 and `sdo`, `sdo_oe`, `latch_clr`, `q_pop` and `rx_hold` are 0.
- R2: `q_pop` is asserted only while the block is idle, `q_empty` is 0, and `host_ready` has read high through SYNC_STAGES synchronizer flops. With `host_ready` low, or with the queue empty, no transfer starts and `sdo_oe` stays 0.
- R3: Each byte is taken with exactly one `q_pop` pulse one cycle wide, at the start of its transfer. `q_data` is captured on that same clock edge.
- R4: Bits leave on `sdo` most significant bit first, so the external register holds the byte in its original bit order after the last clock.
- R5: For every bit, `sdo` is presented for HALF_CYC cycles with `sclk` high. Then `sclk` is low for HALF_CYC cycles, then high for HALF_CYC cycles. `sdo` does not change in the cycle in which `sclk` rises.
- R6: Exactly DATA_W rising edges of `sclk` are produced per byte.
- R7: `sdo_oe` is 1 from the first bit's setup phase to the end of the last bit's high phase, and 0 otherwise. While `sdo_oe` is 0, `sdo` is 0 and `sclk` is 1.
- R8: After the last bit, `latch_clr` is high for HALF_CYC cycles with `sdo_oe` low. It then stays low for at least HALF_CYC cycles before the next `q_pop`.
- R9: `rx_hold` is 1 from the cycle after `q_pop` until the end of the post-clear gap. It is 1 in every cycle where `sdo_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_empty | input | 1 | Scan-code queue has no entry |
| q_data | input | DATA_W | Head entry of the queue |
| q_pop | output | 1 | Remove the head entry (one cycle) |
| sdo | output | 1 | Serial data toward the external register |
| sdo_oe | output | 1 | Drive enable for the shared data pin |
| sclk | output | 1 | Shift clock; the register captures on its rising edge |
| host_ready | input | 1 | Latch output: high when the host has taken the last byte |
| latch_clr | output | 1 | Reset pulse to the external latch |
| rx_hold | output | 1 | Tells the PS/2 receiver to ignore the line |

## Verification
The bench sends all-zero and all-one bytes, where a missing clock pulse cannot be seen in the data but is caught by the edge count. It sends the single-bit bytes 0x80 and 0x01, which expose a reversed bit order. Alternating and mixed patterns (0xA5, 0x5A, 0x3C, 0xC3) expose swapped or shifted bit positions. A byte is queued while the latch reads low, which shows that the latch gates the transfer. The latch is then re-armed with the queue empty, which shows that an empty queue also stops transfers. A back-to-back burst checks the clear pulse width, the gap before the next pop, and the one-pop-per-byte rule under continuous traffic.

// File: rtl/lps_pkg.sv
package lps_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_LOW,
      ST_HIGH,
      ST_CLR,
      ST_GAP
   } lps_state_e;

   typedef struct packed {
      logic sclk;
      logic oe;
      logic clr;
      logic hold;
   } lps_pins_t;

   localparam lps_pins_t PINS_IDLE = '{sclk: 1'b1, oe: 1'b0, clr: 1'b0, hold: 1'b0};

   function automatic lps_pins_t pins_of(lps_state_e s);
      lps_pins_t p;
      p.sclk = (s != ST_LOW);
      p.oe   = (s == ST_SETUP) || (s == ST_LOW) || (s == ST_HIGH);
      p.clr  = (s == ST_CLR);
      p.hold = (s != ST_IDLE);
      return p;
   endfunction

endpackage

// File: rtl/lps_sync.sv
module lps_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               r <= '0;
            end else begin
               r[0] <= d;
               for (int i = 1; i < STAGES; i++) r[i] <= r[i-1];
            end
         end
         assign q = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/lps_halftimer.sv
module lps_halftimer #(
   parameter int HALF_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic expired
);
   localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
   localparam logic [CW-1:0] RELOAD = CW'(HALF_CYC - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt <= '0;
      else if (restart)       cnt <= RELOAD;
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/lps_piso.sv
module lps_piso #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         shift,
   input  logic [W-1:0] din,
   output logic         msb
);
   logic [W-1:0] r;

   always_ff @(posedge clk) begin
      if (!rst_n)      r <= '0;
      else if (load)   r <= din;
      else if (shift)  r <= {r[W-2:0], 1'b0};
   end

   assign msb = r[W-1];
endmodule

// File: rtl/latch_paced_shifter.sv
module latch_paced_shifter
   import lps_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int HALF_CYC    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              q_empty,
   input  logic [DATA_W-1:0] q_data,
   output logic              q_pop,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              sclk,
   input  logic              host_ready,
   output logic              latch_clr,
   output logic              rx_hold
);
   localparam int IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (HALF_CYC < 1) begin : g_bad_half
         $error("HALF_CYC must be at least 1");
      end
      if (2 * HALF_CYC < SYNC_STAGES + 1) begin : g_bad_gap
         $error("clear pulse plus gap too short for the ready synchronizer");
      end
   endgenerate

   lps_state_e     st_q, st_d;
   lps_pins_t      pins_q;
   logic           ready_s;
   logic           expired;
   logic           shift_en;
   logic           msb;
   logic [IDX_W-1:0] bit_idx;

   lps_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (host_ready),
      .q     (ready_s)
   );

   lps_halftimer #(.HALF_CYC(HALF_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (st_d != st_q),
      .expired (expired)
   );

   lps_piso #(.W(DATA_W)) u_piso (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (q_pop),
      .shift (shift_en),
      .din   (q_data),
      .msb   (msb)
   );

   assign q_pop = (st_q == ST_IDLE) && !q_empty && ready_s;

   always_comb begin
      st_d     = st_q;
      shift_en = 1'b0;
      case (st_q)
         ST_IDLE:  if (q_pop)   st_d = ST_SETUP;
         ST_SETUP: if (expired) st_d = ST_LOW;
         ST_LOW:   if (expired) st_d = ST_HIGH;
         ST_HIGH: begin
            if (expired) begin
               if (bit_idx == LAST_IDX) begin
                  st_d = ST_CLR;
               end else begin
                  st_d     = ST_SETUP;
                  shift_en = 1'b1;
               end
            end
         end
         ST_CLR:   if (expired) st_d = ST_GAP;
         ST_GAP:   if (expired) st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         pins_q  <= PINS_IDLE;
         bit_idx <= '0;
      end else begin
         st_q   <= st_d;
         pins_q <= pins_of(st_d);
         if (q_pop)         bit_idx <= '0;
         else if (shift_en) bit_idx <= bit_idx + 1'b1;
      end
   end

   assign sclk      = pins_q.sclk;
   assign sdo_oe    = pins_q.oe;
   assign latch_clr = pins_q.clr;
   assign rx_hold   = pins_q.hold;
   assign sdo       = pins_q.oe & msb;

endmodule

// File: rtl/lps_checker.sv
module lps_checker #(
   parameter int DATA_W = 8
) (
   input logic clk,
   input logic rst_n,
   input logic q_empty,
   input logic q_pop,
   input logic sdo,
   input logic sdo_oe,
   input logic sclk,
   input logic host_ready,
   input logic latch_clr,
   input logic rx_hold
);
   localparam int RW = $clog2(DATA_W + 1) + 1;

   logic          sclk_d;
   logic [RW-1:0] rises;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_d <= 1'b1;
         rises  <= '0;
      end else begin
         sclk_d <= sclk;
         if (q_pop)               rises <= '0;
         else if (sclk && !sclk_d) rises <= rises + 1'b1;
      end
   end

   AST_POP_HAS_DATA:   assert property (@(posedge clk) disable iff (!rst_n) q_pop |-> !q_empty);                 // R2
   AST_POP_LATCH_HIGH: assert property (@(posedge clk) disable iff (!rst_n) q_pop |-> host_ready);               // R2
   AST_POP_SINGLE:     assert property (@(posedge clk) disable iff (!rst_n) q_pop |=> !q_pop);                   // R3
   AST_SDO_STABLE:     assert property (@(posedge clk) disable iff (!rst_n) $rose(sclk) |-> $stable(sdo));       // R5
   AST_EDGE_COUNT:     assert property (@(posedge clk) disable iff (!rst_n) $fell(sdo_oe) |-> rises == RW'(DATA_W)); // R6
   AST_LOW_NEEDS_OE:   assert property (@(posedge clk) disable iff (!rst_n) !sclk |-> sdo_oe);                   // R7
   AST_RELEASED_ZERO:  assert property (@(posedge clk) disable iff (!rst_n) !sdo_oe |-> !sdo);                   // R7
   AST_CLR_NOT_DRIVING:assert property (@(posedge clk) disable iff (!rst_n) latch_clr |-> !sdo_oe && rx_hold);  // R8
   AST_HOLD_COVERS_OE: assert property (@(posedge clk) disable iff (!rst_n) sdo_oe |-> rx_hold);                 // R9
   AST_HOLD_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n) q_pop |=> rx_hold);                   // R9
endmodule

bind latch_paced_shifter lps_checker #(.DATA_W(DATA_W)) u_lps_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .q_empty    (q_empty),
   .q_pop      (q_pop),
   .sdo        (sdo),
   .sdo_oe     (sdo_oe),
   .sclk       (sclk),
   .host_ready (host_ready),
   .latch_clr  (latch_clr),
   .rx_hold    (rx_hold)
);

// File: tb/latch_paced_shifter_test.sv
module latch_paced_shifter_test;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int HC = 4;
   localparam int SS = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [DW-1:0] mem [32];
   logic [4:0]    rd = '0;
   logic [4:0]    wr = '0;
   logic          q_empty, q_pop, sdo, sdo_oe, sclk, latch_clr, rx_hold;
   logic [DW-1:0] q_data;
   logic          lq = 1'b0;
   logic          host_set = 1'b0;
   logic          manual_req = 1'b0;
   logic          auto_host = 1'b0;

   assign q_empty = (rd == wr);
   assign q_data  = mem[rd];

   latch_paced_shifter #(.DATA_W(DW), .HALF_CYC(HC), .SYNC_STAGES(SS)) uut (
      .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .q_data(q_data), .q_pop(q_pop),
      .sdo(sdo), .sdo_oe(sdo_oe), .sclk(sclk), .host_ready(lq),
      .latch_clr(latch_clr), .rx_hold(rx_hold)
   );

   always @(posedge clk) begin
      if (!rst_n)       rd <= '0;
      else if (q_pop)   rd <= rd + 1'b1;
   end

   always @(posedge clk) begin
      if (!rst_n)          lq <= 1'b0;
      else if (latch_clr)  lq <= 1'b0;
      else if (host_set)   lq <= 1'b1;
   end

   always @(negedge clk) host_set <= manual_req || (auto_host && !lq && !latch_clr);

   int n_chk = 0, n_fail = 0;
   int sent = 0, pops = 0, rises = 0, total_rises = 0;
   int oe_bad = 0, setup_bad = 0, hold_bad = 0, low_bad = 0, hold_seen = 0;
   int clr_w = 0, gap = 0, lo_w = 0;
   bit seen_clr = 0, done = 0;
   logic [DW-1:0] cap = '0;
   logic [DW-1:0] expq [$];
   logic sclk_p = 1'b1, sdo_p = 1'b0, clr_p = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [DW-1:0] b);
      @(negedge clk);
      mem[wr] = b;
      wr = wr + 1'b1;
      expq.push_back(b);
      sent++;
   endtask

   task automatic drain();
      while (expq.size() != 0) @(negedge clk);
      repeat (2*HC + 6) @(negedge clk);
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (sdo_oe && !rx_hold) hold_bad++;
         if (rx_hold) hold_seen++;
         if (!sclk) lo_w++;
         if (sclk && !sclk_p) begin
            if (!sdo_oe) oe_bad++;
            if (sdo !== sdo_p) setup_bad++;
            if (lo_w != HC) low_bad++;
            lo_w = 0;
            cap = {cap[DW-2:0], sdo};
            rises++;
            total_rises++;
         end
         if (latch_clr && !clr_p) begin
            if (expq.size() == 0) begin
               chk(0, "R4 unexpected byte", int'(cap), 0);
            end else begin
               chk(cap == expq[0], "R4 captured byte", int'(cap), int'(expq[0]));
               void'(expq.pop_front());
            end
            chk(rises == DW, "R6 clock pulses per byte", rises, DW);
            chk(!sdo_oe, "R8 pin released during clear", int'(sdo_oe), 0);
            rises = 0;
         end
         if (latch_clr) clr_w++;
         else if (clr_p) begin
            chk(clr_w == HC, "R8 clear pulse width", clr_w, HC);
            clr_w = 0;
            gap = 1;
            seen_clr = 1;
         end else if (seen_clr && !q_pop) gap++;
         if (q_pop) begin
            pops++;
            if (seen_clr) chk(gap >= HC, "R8 gap before next pop", gap, HC);
         end
         sclk_p = sclk;
         sdo_p  = sdo;
         clr_p  = latch_clr;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(sclk == 1'b1, "R1 sclk idle", int'(sclk), 1);
      chk({sdo, sdo_oe, latch_clr, q_pop, rx_hold} == 5'b0, "R1 outputs low",
          int'({sdo, sdo_oe, latch_clr, q_pop, rx_hold}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(sclk && !sdo_oe && !rx_hold, "R1 idle after release", int'({sclk, sdo_oe, rx_hold}), 4);

      // latch low: queued byte must wait
      send(8'hA5);
      repeat (150) @(negedge clk);
      chk(pops == 0, "R2 no pop while latch low", pops, 0);
      chk(total_rises == 0 && !sdo_oe, "R2 pin idle while latch low", total_rises, 0);
      manual_req = 1'b1;
      @(negedge clk);
      manual_req = 1'b0;
      drain();
      chk(pops == 1, "R3 one pop for first byte", pops, 1);

      // latch re-armed, queue empty: nothing happens
      auto_host = 1'b1;
      repeat (100) @(negedge clk);
      chk(pops == 1, "R2 no pop with empty queue", pops, 1);
      chk(!rx_hold && !sdo_oe, "R9 hold low when idle", int'({rx_hold, sdo_oe}), 0);

      foreach (pat_list[i]) begin
         send(pat_list[i]);
         drain();
      end

      for (int k = 0; k < 4; k++) send(8'h11 << k | 8'h80 >> k);
      drain();

      chk(pops == sent, "R3 pops equal bytes", pops, sent);
      chk(total_rises == DW*sent, "R6 total clock pulses", total_rises, DW*sent);
      chk(setup_bad == 0, "R5 data stable at rising clock", setup_bad, 0);
      chk(low_bad == 0, "R5 low phase width", low_bad, 0);
      chk(oe_bad == 0, "R7 enable high at every edge", oe_bad, 0);
      chk(!sdo && !sdo_oe && sclk, "R7 released idle pins", int'({sdo, sdo_oe, sclk}), 1);
      chk(hold_bad == 0, "R9 hold covers drive", hold_bad, 0);
      chk(hold_seen > 0, "R9 hold asserted in transfers", hold_seen, 1);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   logic [DW-1:0] pat_list [7] = '{8'h00, 8'hFF, 8'h80, 8'h01, 8'h5A, 8'h3C, 8'hC3};

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         chk(0, "watchdog expired", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule